// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block watches a set of active-low external interrupt request pins and keeps one request flag per pin in a 16-bit register that a processor reads and writes over a simple single-register bus. Every pin has its own two-bit sense select. The select chooses between following the pin level and latching a chosen transition: falling, rising or both. Each pin passes through a synchronizer before any detection.

A flag in level mode tracks the synchronized pin with no memory. A flag in edge mode latches the request. Software can clear it only through a two-step handshake: a read that returned 1 for that bit, then a later write of 0 to that bit. A per-pin acknowledge pulse, raised when the exception for that request is taken, also clears it. A per-pin enable masks the flag to 0 and discards any latched request. The interrupt request output is the OR of all visible flags.

Top module: `irq_flag_reg`

## Requirements
- R1: When reset is released, every bit of `rd_data` reads 0 and `irq_req` is 0.
- R2: Bits 15 down to NUM_PINS of `rd_data` always read 0, and writes to them change nothing.
- R3: With select 00 (level) on an enabled pin, its bit reads 1 while the synchronized pin is low and 0 while it is high, with nothing latched.
- R4: With select 01 (falling), 10 (rising) or 11 (both) on an enabled pin, the bit goes to 1 after the selected transition and stays 1 when the pin returns. A transition that was not selected leaves it 0.
- R5: An edge flag is cleared by a write with a 0 in its bit only if a read during `rd_en` returned 1 for that bit beforehand. A write of 0 with no such read leaves it set, and writing 1 leaves both the flag and the pending read unchanged.
- R6: A one-cycle pulse on `ack[n]` clears the latched edge flag of pin n.
- R7: While `pin_en[n]` is 0, bit n reads 0, and a latched request is discarded, so it stays 0 once the pin is enabled again.
- R8: When a new selected edge and a software clear reach a flag in the same clock, the flag stays 1.
- R9: `irq_req` is 1 exactly when some bit of `rd_data` is 1.
- R10: A pin change is seen in level mode two clocks after it is driven, the depth of the synchronizer, and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | NUM_PINS | Active-low external request pins, asynchronous |
| sense_sel | input | 2*NUM_PINS | Two-bit sense select per pin, pin n at bits 2n+1:2n |
| pin_en | input | NUM_PINS | Per-pin enable; 0 forces the flag to 0 |
| ack | input | NUM_PINS | Per-pin acknowledge pulse that clears an edge flag |
| rd_en | input | 1 | Register read strobe; arms bits read as 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data; a 0 clears an armed edge flag |
| rd_data | output | REG_W | Current visible flags, zero-extended |
| irq_req | output | 1 | OR of all visible flags |

## Verification
The bench uses the default build: eight pins, a 16-bit register and a two-stage synchronizer. It can therefore send vectors to different pins while the others stay masked, and it can count the exact two-clock level latency. With this synchronizer depth the bench can line up a write of 0 with the cycle in which a new edge is detected, so the case where a set and a clear arrive together can be tested. The upper eight register bits exist in this build, so the test that reserved bits read 0 and ignore writes is meaningful.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W         = 8,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= {W{RESET_VAL}};
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= {W{RESET_VAL}};
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
   import irq_flag_pkg::*;
#(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   pin_s_n,
   input  logic [2*W-1:0] sense_sel,
   output logic [W-1:0]   hit,
   output logic [W-1:0]   edge_mode,
   output logic [W-1:0]   level_act
);
   logic [W-1:0] prev_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= '1;
      else        prev_n <= pin_s_n;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      sense_e sel;
      logic   fell, rose;
      assign sel  = sense_e'(sense_sel[2*i +: 2]);
      assign fell = prev_n[i] & ~pin_s_n[i];
      assign rose = ~prev_n[i] & pin_s_n[i];
      always_comb begin
         unique case (sel)
            SENSE_LOW:  hit[i] = 1'b0;
            SENSE_FALL: hit[i] = fell;
            SENSE_RISE: hit[i] = rose;
            SENSE_BOTH: hit[i] = fell | rose;
            default:    hit[i] = 1'b0;
         endcase
      end
      assign edge_mode[i] = (sel != SENSE_LOW);
      assign level_act[i] = ~pin_s_n[i];
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic [W-1:0] edge_mode,
   input  logic [W-1:0] en,
   input  logic [W-1:0] ack,
   input  logic         rd_en,
   input  logic         wr_en,
   input  logic [W-1:0] wr_bits,
   output logic [W-1:0] flag
);
   logic [W-1:0] armed;

   for (genvar i = 0; i < W; i++) begin : g_cell
      logic keep, set_now, sw_clr, clr_now, flag_nx, arm_nx, wr_zero;
      assign keep    = en[i] & edge_mode[i];
      assign set_now = keep & hit[i];
      assign wr_zero = wr_en & ~wr_bits[i];
      assign sw_clr  = wr_zero & armed[i];
      assign clr_now = ack[i] | sw_clr;

      always_comb begin
         if (!keep)        flag_nx = 1'b0;
         else if (set_now) flag_nx = 1'b1;
         else if (clr_now) flag_nx = 1'b0;
         else              flag_nx = flag[i];

         if (!flag_nx)                arm_nx = 1'b0;
         else if (wr_zero)            arm_nx = 1'b0;
         else if (rd_en && flag[i])   arm_nx = 1'b1;
         else                         arm_nx = armed[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag[i]  <= 1'b0;
            armed[i] <= 1'b0;
         end else begin
            flag[i]  <= flag_nx;
            armed[i] <= arm_nx;
         end
      end
   end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
   parameter int NUM_PINS    = 8,
   parameter int REG_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   irq_pin_n,
   input  logic [2*NUM_PINS-1:0] sense_sel,
   input  logic [NUM_PINS-1:0]   pin_en,
   input  logic [NUM_PINS-1:0]   ack,
   input  logic                  rd_en,
   input  logic                  wr_en,
   input  logic [REG_W-1:0]      wr_data,
   output logic [REG_W-1:0]      rd_data,
   output logic                  irq_req
);
   localparam int PAD_W = REG_W - NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > REG_W) begin : g_bad_w
      $error("NUM_PINS must be between 1 and REG_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_s
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pin_s_n, hit, edge_mode, level_act, flag, visible;

   irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_pin_n), .q(pin_s_n)
   );

   irq_edge_det #(.W(NUM_PINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_s_n(pin_s_n), .sense_sel(sense_sel),
      .hit(hit), .edge_mode(edge_mode), .level_act(level_act)
   );

   irq_flag_bank #(.W(NUM_PINS)) u_bank (
      .clk(clk), .rst_n(rst_n), .hit(hit), .edge_mode(edge_mode),
      .en(pin_en), .ack(ack), .rd_en(rd_en), .wr_en(wr_en),
      .wr_bits(wr_data[NUM_PINS-1:0]), .flag(flag)
   );

   assign visible = pin_en & ((edge_mode & flag) | (~edge_mode & level_act));
   assign irq_req = |visible;

   if (PAD_W > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[REG_W-1:NUM_PINS];
      assign rd_data   = {{PAD_W{1'b0}}, visible};
   end else begin : g_nopad
      assign rd_data = visible;
   end
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk #(
   parameter int NUM_PINS = 8,
   parameter int REG_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] pin_en,
   input logic [REG_W-1:0]    rd_data,
   input logic                irq_req
);
   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && !irq_req));

   if (REG_W > NUM_PINS) begin : g_res
      // R2
      reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[REG_W-1:NUM_PINS] == '0);
   end

   // R7
   disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[NUM_PINS-1:0] & ~pin_en) == '0);

   // R9
   irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (rd_data != '0));

   // R7
   enable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en == '0) |-> !irq_req);
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .rd_data(rd_data), .irq_req(irq_req)
);

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;
   localparam int N = 8;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_pin_n = '1;
   logic [2*N-1:0] sense_sel = '0;
   logic [N-1:0]  pin_en = '0;
   logic [N-1:0]  ack = '0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  rd_data;
   logic          irq_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_flag_reg #(.NUM_PINS(N), .REG_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .sense_sel(sense_sel),
      .pin_en(pin_en), .ack(ack), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
   );

   // {pin[2:0], sel[1:0], before, after, expected}
   localparam logic [7:0] VEC [8] = '{
      {3'd0, 2'b00, 1'b1, 1'b0, 1'b1},
      {3'd1, 2'b00, 1'b0, 1'b1, 1'b0},
      {3'd2, 2'b01, 1'b1, 1'b0, 1'b1},
      {3'd3, 2'b01, 1'b0, 1'b1, 1'b0},
      {3'd4, 2'b10, 1'b0, 1'b1, 1'b1},
      {3'd5, 2'b10, 1'b1, 1'b0, 1'b0},
      {3'd6, 2'b11, 1'b1, 1'b0, 1'b1},
      {3'd7, 2'b11, 1'b0, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic do_write(input logic [W-1:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_data", rd_data, '0);
      check("R1 irq_req", {15'd0, irq_req}, '0);

      // Table walk: R3 level, R4 edges, R9 request output
      for (int i = 0; i < 8; i++) begin
         automatic int p = int'(VEC[i][7:5]);
         pin_en[p] = 1'b0;
         irq_pin_n[p] = VEC[i][2];
         sense_sel[2*p +: 2] = VEC[i][4:3];
         cyc(5);
         pin_en[p] = 1'b1;
         cyc(5);
         irq_pin_n[p] = VEC[i][1];
         cyc(5);
         check("R3/R4 table bit", {15'd0, rd_data[p]}, {15'd0, VEC[i][0]});
         check("R9 table irq", {15'd0, irq_req}, {15'd0, VEC[i][0]});
         pin_en[p] = 1'b0;
         irq_pin_n[p] = 1'b1;
         cyc(3);
      end

      // R3 level: no latching once pin returns high
      sense_sel[1:0] = 2'b00; pin_en[0] = 1'b1;
      irq_pin_n[0] = 1'b0; cyc(4);
      irq_pin_n[0] = 1'b1; cyc(4);
      check("R3 release", rd_data, '0);

      // R10 latency: visible after two clocks, not one
      irq_pin_n[0] = 1'b0;
      cyc(1);
      check("R10 one clock", rd_data, '0);
      cyc(1);
      check("R10 two clocks", rd_data, 16'h0001);
      irq_pin_n[0] = 1'b1; pin_en[0] = 1'b0; cyc(4);

      // Edge flag on pin 2 (falling)
      sense_sel[5:4] = 2'b01; pin_en[2] = 1'b1; cyc(4);
      irq_pin_n[2] = 1'b0; cyc(4);
      irq_pin_n[2] = 1'b1; cyc(4);
      check("R4 latched", rd_data, 16'h0004);

      // R2 reserved bits ignore writes of ones
      do_write(16'hFFFF);
      check("R2 reserved", rd_data, 16'h0004);

      // R5 write 0 without prior read keeps the flag
      do_write(16'h0000);
      check("R5 no arm", rd_data, 16'h0004);

      // R5 read then write 1: still set
      do_read();
      do_write(16'hFFFF);
      check("R5 write one", rd_data, 16'h0004);

      // R5 then write 0 clears
      do_write(16'hFFFB);
      check("R5 cleared", rd_data, '0);
      check("R9 idle", {15'd0, irq_req}, '0);

      // R6 acknowledge clears
      irq_pin_n[2] = 1'b0; cyc(4);
      check("R6 set", rd_data, 16'h0004);
      ack[2] = 1'b1; cyc(1); ack[2] = 1'b0; cyc(1);
      check("R6 ack", rd_data, '0);
      irq_pin_n[2] = 1'b1; cyc(4);

      // R7 disable discards latched request
      irq_pin_n[2] = 1'b0; cyc(4);
      irq_pin_n[2] = 1'b1; cyc(4);
      pin_en[2] = 1'b0; cyc(1);
      check("R7 masked", rd_data, '0);
      pin_en[2] = 1'b1; cyc(2);
      check("R7 discarded", rd_data, '0);

      // R8 set wins over simultaneous clear (pin 1, both edges)
      sense_sel[3:2] = 2'b11; pin_en[1] = 1'b1; cyc(4);
      irq_pin_n[1] = 1'b0; cyc(4);
      check("R8 pre", rd_data, 16'h0002);
      do_read();
      irq_pin_n[1] = 1'b1;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h0000;
      @(negedge clk);
      wr_en = 1'b0;
      check("R8 set wins", rd_data, 16'h0002);

      // R1 reset clears latched flags
      rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
      check("R1 after reset", rd_data, '0);

      finish_run();
   end
endmodule